// File: doc/BRIEF.md
# Sized Integer ALU with Five-Flag Condition Codes

This block is the integer execution stage of a processor datapath. Each clock it takes a destination operand, a source operand, an opcode, an operand size and the current five-bit condition code value. On the next rising edge it registers three outputs: the 32-bit value to write back, a write strobe and the updated condition codes. The operation set covers binary and extended add and subtract, negate, compare, the bitwise operations, move, clear, sign extension and half-word swap. Each of these can run on byte, word or long operands.

For byte and word sizes only the low part of the destination changes, and the upper bits pass through. Flags are taken from the sized result. The extend flag is kept apart from carry: arithmetic sets it, while logic operations and compare leave it alone. A separate address mode adds or subtracts at full width and changes no flags.

Top module: `szalu_top`

## Requirements
- R1: While `rst_n` is low, `res_o`, `wr_o` and `ccr_o` are all zero.
- R2: The size codes are 0 = byte (8 bits), 1 = word (16 bits) and 2 = long (32 bits). For byte and word results, `res_o` keeps the destination bits above the size. Size code 3 gives `wr_o`=0 with `ccr_o` equal to `ccr_i`, for every opcode.
- R3: Opcodes ADD=0, SUB=1, ADDX=2 and SUBX=3 compute dst+src, dst-src, dst+src+X and dst-src-X at the selected size. C is the carry or borrow out of the sized result. V is signed overflow at that size. X is set equal to the new C.
- R4: NEG=4 and NEGX=5 compute 0-dst and 0-dst-X, with C, V and X as in R3.
- R5: The condition code bits are [4]=X, [3]=N, [2]=Z, [1]=V and [0]=C. For every flag-setting operation, N is the top bit of the sized result and Z is set when the sized result is zero.
- R6: For ADDX, SUBX and NEGX, the new Z equals the old Z AND'ed with the zero test of the result. A zero result never sets Z.
- R7: CMP=6 sets N, Z, V and C from dst-src, keeps X, and drives `wr_o`=0.
- R8: AND=7, OR=8, XOR=9, NOT=10 (of dst) and MOVE=11 (of src) write the sized result, keep X, and clear V and C.
- R9: CLR=12 writes zero at the selected size and gives N=0, Z=1, V=0 and C=0, with X kept.
- R10: EXT=13 at word size sign-extends dst bits 7:0 into bits 15:0. At long size it sign-extends bits 15:0 into 31:0. N and Z come from that sized result, and V and C are cleared. At byte size it is illegal.
- R11: SWAP=14 at any legal size writes {dst[15:0], dst[31:16]}. It takes N and Z from all 32 bits and clears V and C.
- R12: ADDA=15 and SUBA=16 at word size use the sign-extended low 16 source bits, and at long size the full source. They write the full 32-bit dst±src and leave all flags unchanged. At byte size they are illegal.
- R13: Illegal combinations and opcodes 17 to 31 give `wr_o`=0 and leave `ccr_o` equal to `ccr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 5 | Operation code |
| size_i | input | 2 | Operand size code |
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Source operand |
| ccr_i | input | 5 | Current condition codes |
| res_o | output | 32 | Merged write-back value |
| wr_o | output | 1 | Destination write strobe |
| ccr_o | output | 5 | New condition codes |

## Verification
The hardest cases to reach are the size-boundary carries and overflows combined with an incoming X and a stale Z. Examples are a byte add with carry-in that wraps exactly to zero while Z was clear, or a word subtract whose borrow comes only from X. The stimulus crosses every opcode and size with operand values chosen at each size boundary (0, 1, the signed limits and all ones). Those values carry nonzero upper bits so that pass-through can be seen. Each pair is driven with the input flags both all clear and with X and Z set.

// File: rtl/szalu_pkg.sv
package szalu_pkg;
  localparam int DW = 32;
  localparam int CW = 5;
  localparam int OPW = 5;
  localparam int SZW = 2;

  localparam int FX = 4;
  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FV = 1;
  localparam int FC = 0;

  localparam logic [SZW-1:0] SZ_B   = 2'd0;
  localparam logic [SZW-1:0] SZ_W   = 2'd1;
  localparam logic [SZW-1:0] SZ_L   = 2'd2;
  localparam logic [SZW-1:0] SZ_BAD = 2'd3;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,  OP_SUB  = 5'd1,  OP_ADDX = 5'd2,  OP_SUBX = 5'd3,
    OP_NEG  = 5'd4,  OP_NEGX = 5'd5,  OP_CMP  = 5'd6,  OP_AND  = 5'd7,
    OP_OR   = 5'd8,  OP_XOR  = 5'd9,  OP_NOT  = 5'd10, OP_MOVE = 5'd11,
    OP_CLR  = 5'd12, OP_EXT  = 5'd13, OP_SWAP = 5'd14, OP_ADDA = 5'd15,
    OP_SUBA = 5'd16
  } alu_op_e;

  function automatic logic [DW-1:0] sz_mask(input logic [SZW-1:0] sz);
    case (sz)
      SZ_B:    return 32'h0000_00FF;
      SZ_W:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic sz_msb(input logic [DW-1:0] v, input logic [SZW-1:0] sz);
    case (sz)
      SZ_B:    return v[7];
      SZ_W:    return v[15];
      default: return v[31];
    endcase
  endfunction

  function automatic logic sz_zero(input logic [DW-1:0] v, input logic [SZW-1:0] sz);
    return (v & sz_mask(sz)) == '0;
  endfunction

  function automatic logic [DW-1:0] sz_merge(input logic [DW-1:0] old_v,
                                             input logic [DW-1:0] new_v,
                                             input logic [SZW-1:0] sz);
    return (old_v & ~sz_mask(sz)) | (new_v & sz_mask(sz));
  endfunction
endpackage

// File: rtl/szalu_addsub.sv
module szalu_addsub
  import szalu_pkg::*;
(
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic           cin_i,
  input  logic           sub_i,
  input  logic [SZW-1:0] size_i,
  output logic [DW-1:0]  res_o,
  output logic           co_o,
  output logic           ov_o
);
  logic [DW-1:0] m, am, bm;
  logic [DW:0]   wide;
  logic          sa, sb, sr;

  always_comb begin
    m  = sz_mask(size_i);
    am = a_i & m;
    bm = b_i & m;
    if (sub_i) wide = {1'b0, am} - {1'b0, bm} - {{DW{1'b0}}, cin_i};
    else       wide = {1'b0, am} + {1'b0, bm} + {{DW{1'b0}}, cin_i};
    res_o = wide[DW-1:0] & m;
    case (size_i)
      SZ_B:    co_o = wide[8];
      SZ_W:    co_o = wide[16];
      default: co_o = wide[DW];
    endcase
    sa = sz_msb(a_i, size_i);
    sb = sz_msb(b_i, size_i);
    sr = sz_msb(res_o, size_i);
    ov_o = sub_i ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
  end
endmodule

// File: rtl/szalu_logic.sv
module szalu_logic
  import szalu_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  logic [SZW-1:0] size_i,
  input  logic [DW-1:0]  d_i,
  input  logic [DW-1:0]  s_i,
  output logic [DW-1:0]  res_o
);
  always_comb begin
    case (op_i)
      OP_AND:  res_o = d_i & s_i;
      OP_OR:   res_o = d_i | s_i;
      OP_XOR:  res_o = d_i ^ s_i;
      OP_NOT:  res_o = ~d_i;
      OP_MOVE: res_o = s_i;
      OP_EXT:  res_o = (size_i == SZ_W) ? {{24{d_i[7]}}, d_i[7:0]}
                                        : {{16{d_i[15]}}, d_i[15:0]};
      OP_SWAP: res_o = {d_i[15:0], d_i[31:16]};
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/szalu_top.sv
module szalu_top
  import szalu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [4:0]     op_i,
  input  logic [1:0]     size_i,
  input  logic [31:0]    dst_i,
  input  logic [31:0]    src_i,
  input  logic [4:0]     ccr_i,
  output logic [31:0]    res_o,
  output logic           wr_o,
  output logic [4:0]     ccr_o
);
  alu_op_e       opc;
  logic          legal, writes, is_arith, is_logic, is_addr, use_x, is_cmp;
  logic [SZW-1:0] eff_sz;
  logic [DW-1:0] ar_a, ar_b, ar_res, lg_res, value, merged, src_x, addr_val;
  logic          ar_cin, ar_sub, ar_c, ar_v, flag_n, flag_z;
  logic [CW-1:0] ccr_nxt;
  logic          out_vld;

  assign opc = alu_op_e'(op_i);

  szalu_addsub u_arith (
    .a_i(ar_a), .b_i(ar_b), .cin_i(ar_cin), .sub_i(ar_sub), .size_i(eff_sz),
    .res_o(ar_res), .co_o(ar_c), .ov_o(ar_v)
  );

  szalu_logic u_logic (
    .op_i(op_i), .size_i(eff_sz), .d_i(dst_i), .s_i(src_i), .res_o(lg_res)
  );

  always_comb begin
    legal = 1'b1; writes = 1'b1; is_arith = 1'b0; is_logic = 1'b0;
    is_addr = 1'b0; use_x = 1'b0; is_cmp = 1'b0; ar_sub = 1'b1;
    eff_sz = size_i; ar_a = dst_i; ar_b = src_i;
    case (opc)
      OP_ADD:  begin is_arith = 1'b1; ar_sub = 1'b0; end
      OP_SUB:  is_arith = 1'b1;
      OP_ADDX: begin is_arith = 1'b1; ar_sub = 1'b0; use_x = 1'b1; end
      OP_SUBX: begin is_arith = 1'b1; use_x = 1'b1; end
      OP_NEG:  begin is_arith = 1'b1; ar_a = '0; ar_b = dst_i; end
      OP_NEGX: begin is_arith = 1'b1; ar_a = '0; ar_b = dst_i; use_x = 1'b1; end
      OP_CMP:  begin is_arith = 1'b1; is_cmp = 1'b1; writes = 1'b0; end
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_MOVE, OP_CLR: is_logic = 1'b1;
      OP_EXT:  begin is_logic = 1'b1; legal = (size_i != SZ_B); end
      OP_SWAP: begin is_logic = 1'b1; eff_sz = SZ_L; end
      OP_ADDA, OP_SUBA: begin is_addr = 1'b1; legal = (size_i != SZ_B); end
      default: legal = 1'b0;
    endcase
    if (size_i == SZ_BAD) legal = 1'b0;
    ar_cin = use_x & ccr_i[FX];

    src_x    = (size_i == SZ_W) ? {{16{src_i[15]}}, src_i[15:0]} : src_i;
    addr_val = (opc == OP_SUBA) ? dst_i - src_x : dst_i + src_x;

    value  = is_arith ? ar_res : lg_res;
    merged = is_addr ? addr_val : sz_merge(dst_i, value, eff_sz);
    flag_n = sz_msb(value, eff_sz);
    flag_z = sz_zero(value, eff_sz);

    ccr_nxt = ccr_i;
    if (legal && is_arith) begin
      ccr_nxt[FX] = is_cmp ? ccr_i[FX] : ar_c;
      ccr_nxt[FN] = flag_n;
      ccr_nxt[FZ] = use_x ? (ccr_i[FZ] & flag_z) : flag_z;
      ccr_nxt[FV] = ar_v;
      ccr_nxt[FC] = ar_c;
    end else if (legal && is_logic) begin
      ccr_nxt[FN] = flag_n;
      ccr_nxt[FZ] = flag_z;
      ccr_nxt[FV] = 1'b0;
      ccr_nxt[FC] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_o <= '0; wr_o <= 1'b0; ccr_o <= '0; out_vld <= 1'b0;
    end else begin
      res_o <= merged; wr_o <= legal & writes; ccr_o <= ccr_nxt; out_vld <= 1'b1;
    end
  end

  // Assertions on registered outputs against the inputs of the previous edge
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && $past(op_i) == OP_CMP |-> !wr_o && ccr_o[FX] == $past(ccr_i[FX])); // R7
  AST_ADDR_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && ($past(op_i) == OP_ADDA || $past(op_i) == OP_SUBA) |-> ccr_o == $past(ccr_i)); // R12
  AST_X_FOLLOWS_C: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && $past(op_i) <= OP_NEGX && $past(size_i) != SZ_BAD |-> ccr_o[FX] == ccr_o[FC]); // R3
  AST_LOGIC_VC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && $past(op_i) >= OP_AND && $past(op_i) <= OP_CLR && $past(size_i) != SZ_BAD
    |-> ccr_o[1:0] == 2'b00 && ccr_o[FX] == $past(ccr_i[FX])); // R8
  AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && $past(op_i) == OP_CLR && $past(size_i) != SZ_BAD |-> ccr_o[3:0] == 4'b0100); // R9
  AST_Z_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && ($past(op_i) == OP_ADDX || $past(op_i) == OP_SUBX || $past(op_i) == OP_NEGX)
    && !$past(ccr_i[FZ]) |-> !ccr_o[FZ]); // R6
  AST_BYTE_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && wr_o && $past(size_i) == SZ_B && $past(op_i) != OP_SWAP
    |-> res_o[31:8] == $past(dst_i[31:8])); // R2
  AST_BAD_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && ($past(size_i) == SZ_BAD || $past(op_i) > OP_SUBA)
    |-> !wr_o && ccr_o == $past(ccr_i)); // R13
endmodule

// File: tb/sim_szalu_top.sv
module sim_szalu_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op = '0;
  logic [1:0]  size = '0;
  logic [31:0] dst = '0, src = '0;
  logic [4:0]  ccr = '0;
  logic [31:0] res;
  logic        wr;
  logic [4:0]  ccr_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  szalu_top u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op), .size_i(size), .dst_i(dst), .src_i(src),
    .ccr_i(ccr), .res_o(res), .wr_o(wr), .ccr_o(ccr_out)
  );

  function automatic logic [31:0] pat(input int i);
    case (i)
      0: return 32'h0000_0000;  1: return 32'h0000_0001;  2: return 32'hABCD_127F;
      3: return 32'h5A5A_0080;  4: return 32'h1234_00FF;  5: return 32'h0000_7FFF;
      6: return 32'hC3C3_8000;  7: return 32'h9876_FFFF;  8: return 32'h7FFF_FFFF;
      9: return 32'h8000_0000;  10: return 32'hFFFF_FFFF; default: return 32'h1234_5678;
    endcase
  endfunction

  function automatic string tag_of(input int o, input int s);
    if (s == 3) return "R2";
    if (o <= 3) return "R3";
    if (o <= 5) return "R4";
    if (o == 6) return "R7";
    if (o <= 11) return "R8";
    if (o == 12) return "R9";
    if (o == 13) return (s == 0) ? "R13" : "R10";
    if (o == 14) return "R11";
    if (o <= 16) return (s == 0) ? "R13" : "R12";
    return "R13";
  endfunction

  // Reference model: exact integer arithmetic, range tests for C and V
  task automatic model(input int o, input int s, input logic [31:0] d, input logic [31:0] sv,
                       input logic [4:0] ci, output logic [31:0] er, output logic ew,
                       output logic [4:0] ec);
    int w;
    longint unsigned mask, ud, us, xin;
    longint sd, ss, sres, ures, lo, hi;
    logic [31:0] r;
    logic x, n, z, v, c;
    bit arith, logicop;
    w = (s == 0) ? 8 : (s == 1) ? 16 : 32;
    if (o == 14) w = 32;
    mask = (64'd1 << w) - 1;
    er = 32'h0; ew = 1'b0; ec = ci;
    arith = 0; logicop = 0;
    x = ci[4]; n = ci[3]; z = ci[2]; v = ci[1]; c = ci[0];
    if (s == 3 || o > 16 || ((o == 13 || o >= 15) && s == 0)) return;
    ud = longint'(d) & mask; us = longint'(sv) & mask;
    lo = -(longint'(1) << (w-1)); hi = (longint'(1) << (w-1)) - 1;
    sd = (ud > longint'(hi)) ? longint'(ud) - (longint'(1) << w) : longint'(ud);
    ss = (us > longint'(hi)) ? longint'(us) - (longint'(1) << w) : longint'(us);
    xin = (o == 2 || o == 3 || o == 5) ? longint'(ci[4]) : 0;
    r = '0;
    if (o <= 6) begin
      arith = 1;
      if (o == 0 || o == 2) begin
        ures = longint'(ud + us + xin); sres = sd + ss + longint'(xin);
        c = (ures >> w) != 0;
      end else if (o == 4 || o == 5) begin
        ures = -longint'(ud) - longint'(xin); sres = -sd - longint'(xin);
        c = (ud + xin) > 0;
      end else begin
        ures = longint'(ud) - longint'(us) - longint'(xin); sres = sd - ss - longint'(xin);
        c = (us + xin) > ud;
      end
      v = (sres < lo) || (sres > hi);
      r = 32'(longint'(ures) & longint'(mask));
    end else if (o <= 14) begin
      logicop = 1;
      case (o)
        7: r = d & sv;  8: r = d | sv;  9: r = d ^ sv;  10: r = ~d;  11: r = sv;
        12: r = 32'h0;
        13: r = (s == 1) ? {{24{d[7]}}, d[7:0]} : {{16{d[15]}}, d[15:0]};
        default: r = {d[15:0], d[31:16]};
      endcase
      r = r & 32'(mask);
      v = 0; c = 0;
    end else begin
      er = (o == 15) ? d + ((s == 1) ? {{16{sv[15]}}, sv[15:0]} : sv)
                     : d - ((s == 1) ? {{16{sv[15]}}, sv[15:0]} : sv);
      ew = 1'b1;
      return;
    end
    n = r[w-1];
    if (o == 2 || o == 3 || o == 5) z = ci[2] && (r == 0);
    else z = (r == 0);
    if (arith && o != 6) x = c;
    ec = {x, n, z, v, c};
    er = (d & ~32'(mask)) | r;
    ew = (o != 6);
    if (!arith && !logicop) ec = ci;
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s op=%0d size=%0d dst=%h src=%h ccr=%b actual=%h expected=%h",
               tag, what, op, size, dst, src, ccr, got, exp);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] er;
    logic ew;
    logic [4:0] ec;
    // R1: reset state, with non-zero inputs applied
    op = 5'd0; size = 2'd2; dst = 32'hFFFF_FFFF; src = 32'h1; ccr = 5'b11111;
    repeat (3) @(negedge clk);
    chk("R1", "res", res, 32'h0);
    chk("R1", "wr", {31'b0, wr}, 32'h0);
    chk("R1", "ccr", {27'b0, ccr_out}, 32'h0);
    rst_n = 1'b1;
    for (int o = 0; o < 32; o++) begin
      for (int s = 0; s < 4; s++) begin
        for (int i = 0; i < 12; i++) begin
          for (int j = 0; j < 12; j++) begin
            for (int k = 0; k < 2; k++) begin
              op = 5'(o); size = 2'(s); dst = pat(i); src = pat(j);
              ccr = (k == 0) ? 5'b00000 : 5'b10100;
              model(o, s, dst, src, ccr, er, ew, ec);
              @(negedge clk);
              chk(tag_of(o, s), "wr", {31'b0, wr}, {31'b0, ew});
              if (ew) chk(tag_of(o, s), "res", res, er);
              // R5 covers N/Z generally; R6 for the extended forms
              chk((o == 2 || o == 3 || o == 5) && s != 3 ? "R6" : "R5", "nz",
                  {30'b0, ccr_out[3:2]}, {30'b0, ec[3:2]});
              chk(tag_of(o, s), "xvc", {29'b0, ccr_out[4], ccr_out[1:0]},
                  {29'b0, ec[4], ec[1:0]});
            end
          end
        end
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule